// File: doc/BRIEF.md
# Refresh Ownership Controller for a Serial Memory Link

This block decides which agent keeps the DRAM behind a serial memory link refreshed. There are three candidates: a local interval-driven auto-refresh engine, the DRAM's own self-refresh, or the host on the far side of the link. The block watches the link state (disabled, training, calibration, active) and moves refresh duty between these owners. It sends refresh, self-refresh entry and self-refresh exit commands on a two-bit DRAM command port, one command per cycle at most, and it reports the present owner on a two-bit status output.

Software programs the block through a small write port. One register holds the auto-refresh enable and the fast-exit disable bits. A second holds the staged ("next") link settings, which become the live ("current") settings only while the link is disabled. A third holds a 16-bit restore word that is reloaded on a power-state resume path. Because writes never trigger calibration or DRAM initialization, the resume path can restore refresh control without disturbing the DRAM contents.

Top module: `refresh_owner_ctrl`

## Requirements
- R1: While the synchronous active-low reset is applied, the block settles as follows: command NOP (0), owner self-refresh (1), self_refresh high, current link settings equal to CFG_RST, restore word 0, auto-refresh enabled and fast exit disabled.
- R2: On the first cycle the link state is DISABLE (0) after some other state, if the DRAM is not already in self-refresh, the block issues SRE (2) on the following cycle and the owner becomes self-refresh (1).
- R3: With the fast-exit-disable bit (control bit 1) cleared, the block issues SRX (3) on the first cycle the link is in any state other than DISABLE while the DRAM is in self-refresh.
- R4: With the fast-exit-disable bit set, the DRAM stays in self-refresh through TRAINING (1) and CALIBRATION (2), and SRX is issued on the first cycle the link is L0 (3).
- R5: While the auto-refresh enable (control bit 0) is set and the DRAM is not in self-refresh, the owner is local (0) and a REF (1) command is issued every REF_INTERVAL cycles.
- R6: A write that clears the auto-refresh enable stops the local engine in the same cycle: no local REF follows that write, and the owner becomes host (2).
- R7: A host refresh request becomes a REF command only when the owner is host and the link is L0. In every other case the request is dropped.
- R8: The owner code is always 0, 1 or 2, and no REF is ever issued while the owner is self-refresh.
- R9: Writes to the staged link settings (address 1) reach the current settings one cycle later while the link is DISABLE. In any other link state they leave the current settings unchanged until the link next enters DISABLE.
- R10: A write to address 2 loads the 16-bit restore word. Writes to other addresses leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| link_state | input | 2 | Link state: 0 DISABLE, 1 TRAINING, 2 CALIBRATION, 3 L0 |
| host_ref_req | input | 1 | Host refresh request, one per cycle |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address: 0 control, 1 staged link settings, 2 restore word |
| cfg_wdata | input | DATA_W | Register write data |
| dram_cmd | output | 2 | DRAM command: 0 NOP, 1 REF, 2 SRE, 3 SRX |
| owner | output | 2 | Refresh owner: 0 local, 1 self-refresh, 2 host |
| self_refresh | output | 1 | DRAM is in self-refresh |
| cur_link_cfg | output | CFG_W | Live link settings |
| restore_word | output | RESTORE_W | Saved restore word |

## Verification
The bench targets the hand-over cycles. It checks that the fast-exit bit moves SRX from the first training cycle to the first L0 cycle. A design that ignored the bit would exit self-refresh during training, and one that delayed the exit would drop the first host refresh. The bench clears auto-refresh exactly one cycle before a local refresh is due, so a design that gated the engine on the registered enable would let one extra REF through. It also writes staged settings while the link is active and confirms that the current settings stay frozen until DISABLE returns; a design that copied them at any time would retune a running link.

// File: rtl/rfo_pkg.sv
package rfo_pkg;

   typedef enum logic [1:0] {
      LNK_DISABLE = 2'd0,
      LNK_TRAIN   = 2'd1,
      LNK_CALIB   = 2'd2,
      LNK_ACTIVE  = 2'd3
   } link_e;

   typedef enum logic [1:0] {
      OWN_LOCAL = 2'd0,
      OWN_SELF  = 2'd1,
      OWN_HOST  = 2'd2
   } owner_e;

   typedef enum logic [1:0] {
      CMD_NOP = 2'd0,
      CMD_REF = 2'd1,
      CMD_SRE = 2'd2,
      CMD_SRX = 2'd3
   } dcmd_e;

   localparam logic [1:0] ADDR_CTRL    = 2'd0;
   localparam logic [1:0] ADDR_NEXT    = 2'd1;
   localparam logic [1:0] ADDR_RESTORE = 2'd2;

   localparam int CTRL_AREF_BIT  = 0;
   localparam int CTRL_FXDIS_BIT = 1;

endpackage

// File: rtl/rfo_cfg_regs.sv
module rfo_cfg_regs
   import rfo_pkg::*;
#(
   parameter int               DATA_W    = 16,
   parameter int               CFG_W     = 8,
   parameter int               RESTORE_W = 16,
   parameter logic [CFG_W-1:0] CFG_RST   = '0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 we,
   input  logic [1:0]           addr,
   input  logic [DATA_W-1:0]    wdata,
   input  logic                 in_disable,
   output logic                 aref_en_q,
   output logic                 aref_en_n,
   output logic                 fxdis_q,
   output logic [CFG_W-1:0]     cur_cfg,
   output logic [RESTORE_W-1:0] restore_q
);

   logic             fxdis_n;
   logic [CFG_W-1:0] next_q;
   logic [CFG_W-1:0] next_n;

   always_comb begin
      aref_en_n = aref_en_q;
      fxdis_n   = fxdis_q;
      next_n    = next_q;
      if (we && addr == ADDR_CTRL) begin
         aref_en_n = wdata[CTRL_AREF_BIT];
         fxdis_n   = wdata[CTRL_FXDIS_BIT];
      end
      if (we && addr == ADDR_NEXT) begin
         next_n = wdata[CFG_W-1:0];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         aref_en_q <= 1'b1;
         fxdis_q   <= 1'b1;
         next_q    <= CFG_RST;
         cur_cfg   <= CFG_RST;
         restore_q <= '0;
      end else begin
         aref_en_q <= aref_en_n;
         fxdis_q   <= fxdis_n;
         next_q    <= next_n;
         if (in_disable) begin
            cur_cfg <= next_n;
         end
         if (we && addr == ADDR_RESTORE) begin
            restore_q <= wdata[RESTORE_W-1:0];
         end
      end
   end

endmodule

// File: rtl/rfo_selfref.sv
module rfo_selfref
   import rfo_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  link_e link,
   input  logic  fxdis,
   output logic  sr_q,
   output logic  sre,
   output logic  srx
);

   link_e link_q;
   logic  entering_dis;
   logic  exit_ok;

   always_comb begin
      entering_dis = (link == LNK_DISABLE) && (link_q != LNK_DISABLE);
      sre          = entering_dis && !sr_q;
      exit_ok      = fxdis ? (link == LNK_ACTIVE) : (link != LNK_DISABLE);
      srx          = sr_q && exit_ok;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         link_q <= LNK_DISABLE;
         sr_q   <= 1'b1;
      end else begin
         link_q <= link;
         if (sre) begin
            sr_q <= 1'b1;
         end else if (srx) begin
            sr_q <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/rfo_aref_timer.sv
module rfo_aref_timer #(
   parameter int INTERVAL   = 64,
   parameter bit COUNT_DOWN = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic fire
);

   localparam int CNT_W = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(INTERVAL - 1);

   logic [CNT_W-1:0] cnt;

   generate
      if (COUNT_DOWN) begin : g_down
         assign fire = en && (cnt == '0);
         always_ff @(posedge clk) begin
            if (!rst_n || !en || fire) begin
               cnt <= LAST;
            end else begin
               cnt <= cnt - 1'b1;
            end
         end
      end else begin : g_up
         assign fire = en && (cnt == LAST);
         always_ff @(posedge clk) begin
            if (!rst_n || !en || fire) begin
               cnt <= '0;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/refresh_owner_ctrl.sv
module refresh_owner_ctrl
   import rfo_pkg::*;
#(
   parameter int               DATA_W       = 16,
   parameter int               CFG_W        = 8,
   parameter int               RESTORE_W    = 16,
   parameter logic [CFG_W-1:0] CFG_RST      = '0,
   parameter int               REF_INTERVAL = 64,
   parameter bit               COUNT_DOWN   = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [1:0]           link_state,
   input  logic                 host_ref_req,
   input  logic                 cfg_we,
   input  logic [1:0]           cfg_addr,
   input  logic [DATA_W-1:0]    cfg_wdata,
   output logic [1:0]           dram_cmd,
   output logic [1:0]           owner,
   output logic                 self_refresh,
   output logic [CFG_W-1:0]     cur_link_cfg,
   output logic [RESTORE_W-1:0] restore_word
);

   if (REF_INTERVAL < 2) begin : g_bad_interval
      $error("REF_INTERVAL must be at least 2");
   end
   if (DATA_W < CFG_W || DATA_W < RESTORE_W || DATA_W < 2) begin : g_bad_width
      $error("DATA_W must cover CFG_W, RESTORE_W and the control bits");
   end

   link_e link;
   logic  aref_en_q, aref_en_n, fxdis_q;
   logic  sr_q, sre, srx;
   logic  local_en, local_fire, host_ok;
   dcmd_e cmd_n, cmd_q;

   assign link = link_e'(link_state);

   rfo_cfg_regs #(
      .DATA_W    (DATA_W),
      .CFG_W     (CFG_W),
      .RESTORE_W (RESTORE_W),
      .CFG_RST   (CFG_RST)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .we         (cfg_we),
      .addr       (cfg_addr),
      .wdata      (cfg_wdata),
      .in_disable (link == LNK_DISABLE),
      .aref_en_q  (aref_en_q),
      .aref_en_n  (aref_en_n),
      .fxdis_q    (fxdis_q),
      .cur_cfg    (cur_link_cfg),
      .restore_q  (restore_word)
   );

   rfo_selfref u_sr (
      .clk   (clk),
      .rst_n (rst_n),
      .link  (link),
      .fxdis (fxdis_q),
      .sr_q  (sr_q),
      .sre   (sre),
      .srx   (srx)
   );

   assign local_en = aref_en_n && !sr_q && !sre;

   rfo_aref_timer #(
      .INTERVAL   (REF_INTERVAL),
      .COUNT_DOWN (COUNT_DOWN)
   ) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (local_en),
      .fire  (local_fire)
   );

   assign host_ok = host_ref_req && !sr_q && !aref_en_n && !sre && (link == LNK_ACTIVE);

   always_comb begin
      if (sre)             cmd_n = CMD_SRE;
      else if (srx)        cmd_n = CMD_SRX;
      else if (local_fire) cmd_n = CMD_REF;
      else if (host_ok)    cmd_n = CMD_REF;
      else                 cmd_n = CMD_NOP;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) cmd_q <= CMD_NOP;
      else        cmd_q <= cmd_n;
   end

   assign dram_cmd     = cmd_q;
   assign self_refresh = sr_q;
   assign owner        = sr_q ? OWN_SELF : (aref_en_q ? OWN_LOCAL : OWN_HOST);

endmodule

// File: rtl/rfo_checker.sv
module rfo_checker #(
   parameter int CFG_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic [1:0]       link_state,
   input logic             host_ref_req,
   input logic [1:0]       dram_cmd,
   input logic [1:0]       owner,
   input logic [CFG_W-1:0] cur_link_cfg
);

   p_disable_gives_self_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (link_state == 2'd0) |=> (owner == 2'd1));

   p_sre_only_self_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (dram_cmd == 2'd2) |-> (owner == 2'd1));

   p_srx_leaves_self_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (dram_cmd == 2'd3) |-> (owner != 2'd1));

   p_single_srx_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (dram_cmd == 2'd3) |=> (dram_cmd != 2'd3));

   p_host_ref_l0_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (dram_cmd == 2'd1 && owner == 2'd2) |-> ($past(host_ref_req) && $past(link_state) == 2'd3));

   p_owner_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
      owner != 2'd3);

   p_no_ref_in_self_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (owner == 2'd1) |-> (dram_cmd != 2'd1));

   p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(link_state) != 2'd0) |-> $stable(cur_link_cfg));

endmodule

bind refresh_owner_ctrl rfo_checker #(.CFG_W(CFG_W)) u_rfo_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .link_state   (link_state),
   .host_ref_req (host_ref_req),
   .dram_cmd     (dram_cmd),
   .owner        (owner),
   .cur_link_cfg (cur_link_cfg)
);

// File: tb/tb_refresh_owner_ctrl.sv
`timescale 1ns/1ps
module tb_refresh_owner_ctrl;

   localparam int CFG_W = 8;
   localparam logic [CFG_W-1:0] CFG_RST = 8'h3C;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [1:0]  link_state;
   logic        host_ref_req;
   logic        cfg_we;
   logic [1:0]  cfg_addr;
   logic [15:0] cfg_wdata;
   logic [1:0]  dram_cmd;
   logic [1:0]  owner;
   logic        self_refresh;
   logic [7:0]  cur_link_cfg;
   logic [15:0] restore_word;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   refresh_owner_ctrl #(
      .DATA_W(16), .CFG_W(CFG_W), .RESTORE_W(16), .CFG_RST(CFG_RST),
      .REF_INTERVAL(4), .COUNT_DOWN(1'b0)
   ) dut (
      .clk(clk), .rst_n(rst_n), .link_state(link_state), .host_ref_req(host_ref_req),
      .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .dram_cmd(dram_cmd), .owner(owner), .self_refresh(self_refresh),
      .cur_link_cfg(cur_link_cfg), .restore_word(restore_word)
   );

   typedef struct packed {
      logic [1:0]  link;
      logic        we;
      logic [1:0]  addr;
      logic [15:0] wdata;
      logic        host;
      logic [1:0]  cmd;
      logic [1:0]  own;
   } vec_t;

   // link: 0 DIS 1 TRAIN 2 CAL 3 L0; cmd: 0 NOP 1 REF 2 SRE 3 SRX; owner: 0 local 1 self 2 host
   localparam vec_t VEC [22] = '{
      '{2'd1, 1'b0, 2'd0, 16'h0, 1'b0, 2'd0, 2'd1}, // R4 training, stay in self-refresh
      '{2'd2, 1'b0, 2'd0, 16'h0, 1'b0, 2'd0, 2'd1}, // R4 calibration, stay
      '{2'd3, 1'b0, 2'd0, 16'h0, 1'b0, 2'd3, 2'd0}, // R4 SRX on L0
      '{2'd3, 1'b0, 2'd0, 16'h0, 1'b0, 2'd0, 2'd0}, // R5
      '{2'd3, 1'b0, 2'd0, 16'h0, 1'b0, 2'd0, 2'd0}, // R5
      '{2'd3, 1'b0, 2'd0, 16'h0, 1'b0, 2'd0, 2'd0}, // R5
      '{2'd3, 1'b0, 2'd0, 16'h0, 1'b0, 2'd1, 2'd0}, // R5 local REF after 4
      '{2'd3, 1'b0, 2'd0, 16'h0, 1'b1, 2'd0, 2'd0}, // R7 host ignored while local
      '{2'd3, 1'b0, 2'd0, 16'h0, 1'b0, 2'd0, 2'd0}, // R5
      '{2'd3, 1'b0, 2'd0, 16'h0, 1'b0, 2'd0, 2'd0}, // R5
      '{2'd3, 1'b1, 2'd0, 16'h0, 1'b0, 2'd0, 2'd2}, // R6 clear enable on due cycle
      '{2'd3, 1'b0, 2'd0, 16'h0, 1'b1, 2'd1, 2'd2}, // R7 host REF in L0
      '{2'd3, 1'b0, 2'd0, 16'h0, 1'b0, 2'd0, 2'd2}, // R6 no local REF
      '{2'd0, 1'b0, 2'd0, 16'h0, 1'b0, 2'd2, 2'd1}, // R2 SRE on DISABLE
      '{2'd0, 1'b0, 2'd0, 16'h0, 1'b1, 2'd0, 2'd1}, // R7 host ignored in self-refresh
      '{2'd1, 1'b0, 2'd0, 16'h0, 1'b1, 2'd3, 2'd2}, // R3 fast SRX on training
      '{2'd3, 1'b0, 2'd0, 16'h0, 1'b1, 2'd1, 2'd2}, // R7 host REF
      '{2'd3, 1'b1, 2'd0, 16'h1, 1'b0, 2'd0, 2'd0}, // R5 re-enable local
      '{2'd3, 1'b0, 2'd0, 16'h0, 1'b0, 2'd0, 2'd0}, // R5
      '{2'd3, 1'b0, 2'd0, 16'h0, 1'b0, 2'd0, 2'd0}, // R5
      '{2'd3, 1'b0, 2'd0, 16'h0, 1'b0, 2'd1, 2'd0}, // R5 REF
      '{2'd0, 1'b0, 2'd0, 16'h0, 1'b0, 2'd2, 2'd1}  // R2 SRE
   };

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0h expected %0h", req, got, exp);
      end
   endtask

   task automatic drive(input logic [1:0] l, input logic w, input logic [1:0] a,
                        input logic [15:0] d, input logic h);
      link_state = l; cfg_we = w; cfg_addr = a; cfg_wdata = d; host_ref_req = h;
      @(negedge clk);
   endtask

   task automatic finish_run();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog: got hung expected done");
         finish_run();
      end
   end

   initial begin
      rst_n = 1'b0;
      link_state = 2'd3; host_ref_req = 1'b1; cfg_we = 1'b0; cfg_addr = 2'd0; cfg_wdata = '0;
      @(negedge clk); @(negedge clk); @(negedge clk);
      // R1 reset state
      check("R1 cmd", dram_cmd, 0);
      check("R1 owner", owner, 1);
      check("R1 self_refresh", self_refresh, 1);
      check("R1 cur_cfg", cur_link_cfg, CFG_RST);
      check("R1 restore", restore_word, 0);
      link_state = 2'd0; host_ref_req = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < 22; i++) begin
         drive(VEC[i].link, VEC[i].we, VEC[i].addr, VEC[i].wdata, VEC[i].host);
         check($sformatf("R2-7 row %0d cmd", i), dram_cmd, VEC[i].cmd);
         check($sformatf("R8 row %0d owner", i), owner, VEC[i].own);
      end

      // R9 copy while DISABLE
      drive(2'd0, 1'b1, 2'd1, 16'h00A5, 1'b0);
      check("R9 copy in DISABLE", cur_link_cfg, 8'hA5);
      drive(2'd1, 1'b0, 2'd0, 16'h0, 1'b0);
      drive(2'd3, 1'b1, 2'd1, 16'h005A, 1'b0);
      check("R9 frozen in L0", cur_link_cfg, 8'hA5);
      drive(2'd3, 1'b0, 2'd0, 16'h0, 1'b0);
      check("R9 still frozen", cur_link_cfg, 8'hA5);
      drive(2'd0, 1'b0, 2'd0, 16'h0, 1'b0);
      check("R9 staged value lands on DISABLE", cur_link_cfg, 8'h5A);

      // R10 restore word
      drive(2'd0, 1'b1, 2'd2, 16'hBEEF, 1'b0);
      check("R10 restore load", restore_word, 16'hBEEF);
      drive(2'd0, 1'b1, 2'd1, 16'h1234, 1'b0);
      check("R10 restore unchanged", restore_word, 16'hBEEF);

      // R4 fast exit disabled again: training keeps self-refresh, L0 exits
      drive(2'd0, 1'b1, 2'd0, 16'h0003, 1'b0);
      drive(2'd1, 1'b0, 2'd0, 16'h0, 1'b0);
      check("R4 no exit in training", self_refresh, 1);
      drive(2'd3, 1'b0, 2'd0, 16'h0, 1'b0);
      check("R4 SRX at L0", dram_cmd, 3);

      done = 1'b1;
      finish_run();
   end

endmodule